// File: doc/BRIEF.md
# Comparator-Feedback Charge-Balancing ADC Controller

This block is the digital half of a first-order charge-balancing converter. An external comparator compares the unknown voltage with the RC-filtered copy of one feedback pin. On every sample tick the controller reads the comparator. It drives the feedback pin high when the filtered level is below the input and low when it is above. Over time the average duty of the pin settles to the input level.

A measurement begins with a settling interval that uses the same feedback rule but counts nothing. A counting window follows, and in it every tick that drives the pin high adds one to a counter. When the window closes, the count is returned as the result.

The window length is half of a writable calibration word. The comparator's input polarity is swapped after each measurement so that offsets cancel across consecutive pairs. Sample ticks come from a programmable prescaler. The comparator signal passes through a two-flop synchronizer before it is used.

Top module: `cmpfb_adc_ctrl`

## Requirements
- R1: After reset the controller is idle: busy, done, fb_out, cmp_en and cmp_swap are 0, result is 0, and cal_value is 2800.
- R2: A start pulse while idle raises busy and cmp_en on the next clock. Both stay high for the whole measurement and both drop in the clock where done is pulsed.
- R3: Every measurement begins with exactly 1000 sample ticks of settling, during which the counter never changes whatever the comparator does.
- R4: The counting window lasts cal_value shifted right by one (cal_value/2, rounded down) sample ticks. The window length is taken when the measurement starts.
- R5: On each tick, a comparator reading of 0 sets fb_out to 1 and, inside the window, adds one to the count. A reading of 1 sets fb_out to 0 and leaves the count unchanged.
- R6: fb_out is forced to 0 in the clock where the window ends, and it stays 0 while idle.
- R7: done is a single-clock pulse. result takes the final count in that same clock and holds it until the next done.
- R8: cmp_swap inverts at the end of every measurement.
- R9: A cal_value of 0 or 1 gives a zero-length window. The measurement then ends right after settling, with result 0.
- R10: The count saturates at all ones and does not wrap.
- R11: A sample tick occurs once every tick_div+1 clocks while busy, so one measurement keeps busy high for (tick_div+1)*(1000 + cal_value/2) clocks.
- R12: A start pulse received while busy is ignored. The running measurement continues unchanged and gives exactly one done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_div | input | DIV_W | Prescaler value; one tick every tick_div+1 clocks |
| cal_wr | input | 1 | Write strobe for the calibration register |
| cal_wdata | input | CAL_W | Calibration value to write |
| cal_value | output | CAL_W | Current calibration value |
| start | input | 1 | Measurement request |
| cmp_in | input | 1 | Asynchronous comparator output |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-clock completion pulse |
| cmp_en | output | 1 | Comparator power enable |
| cmp_swap | output | 1 | Comparator terminal-swap control |
| fb_out | output | 1 | Feedback drive into the RC filter |
| result | output | RES_W | Last measurement count |

## Verification
The bench holds the comparator low during settling and then switches it high before the window opens. A design that counted during settling would return a nonzero result here. It also measures how long busy stays high, both with the prescaler active and with calibration values 0 and 1. A window that is off by one tick, a window that ignores the halving, or a zero-length window that wraps around to a huge count each shows up as a wrong busy length. A second start pulse mid-run must not restart the sequence or add a done pulse. A narrow-counter instance is driven with a window longer than its range and must return all ones rather than a wrapped value.

// File: rtl/cmpfb_adc_pkg.sv
package cmpfb_adc_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SETTLE = 2'd1,
    SEQ_COUNT  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/cmpfb_sync.sv
module cmpfb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cmpfb_tick_gen.sv
module cmpfb_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else              cnt <= cnt + DIV_W'(1);
  end

  assign tick = run && (cnt == div);
endmodule

// File: rtl/cmpfb_cal_reg.sv
module cmpfb_cal_reg #(
  parameter int CAL_W   = 16,
  parameter int CAL_RST = 2800
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CAL_W-1:0] wdata,
  output logic [CAL_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)     value <= CAL_W'(CAL_RST);
    else if (wr) value <= wdata;
  end
endmodule

// File: rtl/cmpfb_seq.sv
module cmpfb_seq
  import cmpfb_adc_pkg::*;
#(
  parameter int CAL_W        = 16,
  parameter int RES_W        = 16,
  parameter int SETTLE_TICKS = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             tick,
  input  logic             cmp_s,
  input  logic [CAL_W-2:0] win_len,
  output logic             busy,
  output logic             done,
  output logic             cmp_en,
  output logic             cmp_swap,
  output logic             fb_out,
  output logic [RES_W-1:0] result
);
  localparam int SET_W = $clog2(SETTLE_TICKS + 1);
  localparam int PH_W  = (SET_W > CAL_W) ? SET_W : CAL_W;
  localparam logic [PH_W-1:0] SET_LAST = PH_W'(SETTLE_TICKS - 1);

  seq_state_t       state;
  logic [PH_W-1:0]  phase;
  logic [CAL_W-2:0] win;
  logic [RES_W-1:0] acc;
  logic [RES_W-1:0] acc_nxt;
  logic [PH_W-1:0]  win_last;
  logic             inc;
  logic             fin;

  assign win_last = PH_W'(win) - PH_W'(1);
  assign inc      = !cmp_s && (acc != {RES_W{1'b1}});
  assign acc_nxt  = acc + RES_W'(inc);
  assign fin = tick && (((state == SEQ_SETTLE) && (phase == SET_LAST) && (win == '0)) ||
                        ((state == SEQ_COUNT)  && (phase == win_last)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      phase    <= '0;
      win      <= '0;
      acc      <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      cmp_en   <= 1'b0;
      cmp_swap <= 1'b0;
      fb_out   <= 1'b0;
      result   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (start) begin
            state  <= SEQ_SETTLE;
            busy   <= 1'b1;
            cmp_en <= 1'b1;
            acc    <= '0;
            phase  <= '0;
            win    <= win_len;
          end
        end
        SEQ_SETTLE: begin
          if (tick) begin
            fb_out <= !cmp_s;
            if (phase == SET_LAST) begin
              phase <= '0;
              state <= SEQ_COUNT;
            end else begin
              phase <= phase + PH_W'(1);
            end
          end
        end
        SEQ_COUNT: begin
          if (tick) begin
            fb_out <= !cmp_s;
            acc    <= acc_nxt;
            phase  <= phase + PH_W'(1);
          end
        end
        default: state <= SEQ_IDLE;
      endcase

      if (fin) begin
        state    <= SEQ_IDLE;
        busy     <= 1'b0;
        cmp_en   <= 1'b0;
        fb_out   <= 1'b0;
        done     <= 1'b1;
        cmp_swap <= !cmp_swap;
        result   <= (state == SEQ_COUNT) ? acc_nxt : '0;
      end
    end
  end
endmodule

// File: rtl/cmpfb_adc_ctrl.sv
module cmpfb_adc_ctrl #(
  parameter int DIV_W        = 8,
  parameter int CAL_W        = 16,
  parameter int RES_W        = 16,
  parameter int CAL_RST      = 2800,
  parameter int SETTLE_TICKS = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] tick_div,
  input  logic             cal_wr,
  input  logic [CAL_W-1:0] cal_wdata,
  output logic [CAL_W-1:0] cal_value,
  input  logic             start,
  input  logic             cmp_in,
  output logic             busy,
  output logic             done,
  output logic             cmp_en,
  output logic             cmp_swap,
  output logic             fb_out,
  output logic [RES_W-1:0] result
);
  logic cmp_s;
  logic tick;

  cmpfb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(cmp_in), .q(cmp_s)
  );

  cmpfb_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(busy), .div(tick_div), .tick(tick)
  );

  cmpfb_cal_reg #(.CAL_W(CAL_W), .CAL_RST(CAL_RST)) u_cal (
    .clk(clk), .rst(rst), .wr(cal_wr), .wdata(cal_wdata), .value(cal_value)
  );

  cmpfb_seq #(.CAL_W(CAL_W), .RES_W(RES_W), .SETTLE_TICKS(SETTLE_TICKS)) u_seq (
    .clk(clk), .rst(rst), .start(start), .tick(tick), .cmp_s(cmp_s),
    .win_len(cal_value[CAL_W-1:1]),
    .busy(busy), .done(done), .cmp_en(cmp_en), .cmp_swap(cmp_swap),
    .fb_out(fb_out), .result(result)
  );
endmodule

// File: rtl/cmpfb_adc_ctrl_chk.sv
module cmpfb_adc_ctrl_chk #(
  parameter int RES_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             cmp_en,
  input logic             cmp_swap,
  input logic             fb_out,
  input logic [RES_W-1:0] result
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && cmp_en));
  // R2
  enable_span_chk: assert property (@(posedge clk) disable iff (rst) busy |-> cmp_en);
  // R8
  swap_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (cmp_swap != $past(cmp_swap)));
  // R6
  end_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!fb_out && !busy && !cmp_en));
  // R6
  idle_fb_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> !fb_out);
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));
endmodule

bind cmpfb_adc_ctrl cmpfb_adc_ctrl_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .cmp_en(cmp_en), .cmp_swap(cmp_swap), .fb_out(fb_out), .result(result)
);

// File: tb/cmpfb_adc_ctrl_tb.sv
module cmpfb_adc_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  tick_div = '0;
  logic        cal_wr = 1'b0;
  logic [15:0] cal_wdata = '0;
  logic [15:0] cal_value;
  logic        start = 1'b0;
  logic        cmp_in = 1'b0;
  logic        busy, done, cmp_en, cmp_swap, fb_out;
  logic [15:0] result;

  logic        sat_start = 1'b0;
  logic [15:0] sat_cal;
  logic        sat_busy, sat_done, sat_en, sat_swap, sat_fb;
  logic [7:0]  sat_result;

  int checks = 0;
  int fails  = 0;
  bit exp_swap = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cmpfb_adc_ctrl u_dut (
    .clk(clk), .rst(rst), .tick_div(tick_div), .cal_wr(cal_wr), .cal_wdata(cal_wdata),
    .cal_value(cal_value), .start(start), .cmp_in(cmp_in), .busy(busy), .done(done),
    .cmp_en(cmp_en), .cmp_swap(cmp_swap), .fb_out(fb_out), .result(result)
  );

  cmpfb_adc_ctrl #(.RES_W(8)) u_sat (
    .clk(clk), .rst(rst), .tick_div(8'd0), .cal_wr(1'b0), .cal_wdata(16'd0),
    .cal_value(sat_cal), .start(sat_start), .cmp_in(cmp_in), .busy(sat_busy),
    .done(sat_done), .cmp_en(sat_en), .cmp_swap(sat_swap), .fb_out(sat_fb),
    .result(sat_result)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_cal(input int v);
    @(negedge clk); cal_wr = 1'b1; cal_wdata = 16'(v);
    @(negedge clk); cal_wr = 1'b0;
  endtask

  task automatic run_meas(input int chg_at, input bit chg_val, input int poke_at,
                          input int probe_at, output int bcyc, output int dpulses,
                          output bit fbp, output bit en_ok, output bit fb_after,
                          output bit done_after);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    bcyc = 0; dpulses = 0; fbp = 1'b0; en_ok = 1'b1;
    while (busy) begin
      bcyc++;
      if (!cmp_en) en_ok = 1'b0;
      if (done) dpulses++;
      if (bcyc == chg_at) cmp_in = chg_val;
      if (bcyc == probe_at) fbp = fb_out;
      start = (bcyc == poke_at);
      @(negedge clk);
    end
    start = 1'b0;
    if (done) dpulses++;
    fb_after = fb_out;
    if (cmp_en) en_ok = 1'b0;
    exp_swap = !exp_swap;
    @(negedge clk);
    done_after = done;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "fb_out", fb_out, 0);
    chk("R1", "cmp_en", cmp_en, 0);
    chk("R1", "cmp_swap", cmp_swap, 0);
    chk("R1", "result", result, 0);
    chk("R1", "cal_value", cal_value, 2800);
  endtask

  task automatic t_default_low();
    int b, d; bit fp, eo, fa, da;
    cmp_in = 1'b0; repeat (5) @(negedge clk);
    run_meas(-1, 1'b0, -1, 200, b, d, fp, eo, fa, da);
    chk("R3", "busy cycles default cal", b, 2400);
    chk("R5", "result comparator low", result, 1400);
    chk("R5", "fb during settling", fp, 1);
    chk("R2", "cmp_en span", eo, 1);
    chk("R6", "fb after window", fa, 0);
    chk("R7", "done pulses", d, 1);
    chk("R7", "done width", da, 0);
    chk("R8", "swap after first", cmp_swap, exp_swap);
  endtask

  task automatic t_high();
    int b, d; bit fp, eo, fa, da;
    cmp_in = 1'b1; repeat (5) @(negedge clk);
    run_meas(-1, 1'b0, -1, 1500, b, d, fp, eo, fa, da);
    chk("R5", "result comparator high", result, 0);
    chk("R5", "fb in window comparator high", fp, 0);
    chk("R8", "swap after second", cmp_swap, exp_swap);
  endtask

  task automatic t_settle_only();
    int b, d; bit fp, eo, fa, da;
    cmp_in = 1'b0; repeat (5) @(negedge clk);
    run_meas(500, 1'b1, -1, 1500, b, d, fp, eo, fa, da);
    chk("R3", "no count during settling", result, 0);
    chk("R5", "fb follows comparator high", fp, 0);
    chk("R3", "busy cycles", b, 2400);
    cmp_in = 1'b0;
    repeat (50) @(negedge clk);
    chk("R7", "result holds while idle", result, 0);
    chk("R6", "fb idle low with comparator low", fb_out, 0);
  endtask

  task automatic t_prescale();
    int b, d; bit fp, eo, fa, da;
    write_cal(20);
    chk("R4", "cal write", cal_value, 20);
    tick_div = 8'd3; cmp_in = 1'b0; repeat (5) @(negedge clk);
    run_meas(-1, 1'b0, -1, -1, b, d, fp, eo, fa, da);
    chk("R11", "busy cycles prescaled", b, 4040);
    chk("R4", "window of cal/2", result, 10);
    tick_div = 8'd0;
  endtask

  task automatic t_zero();
    int b, d; bit fp, eo, fa, da;
    cmp_in = 1'b0;
    write_cal(1);
    run_meas(-1, 1'b0, -1, -1, b, d, fp, eo, fa, da);
    chk("R9", "cal=1 busy cycles", b, 1000);
    chk("R9", "cal=1 result", result, 0);
    chk("R9", "cal=1 done pulses", d, 1);
    write_cal(0);
    run_meas(-1, 1'b0, -1, -1, b, d, fp, eo, fa, da);
    chk("R9", "cal=0 busy cycles", b, 1000);
    chk("R9", "cal=0 result", result, 0);
    chk("R6", "cal=0 fb after", fa, 0);
  endtask

  task automatic t_busy_start();
    int b, d; bit fp, eo, fa, da;
    write_cal(201);
    cmp_in = 1'b0;
    run_meas(-1, 1'b0, 300, -1, b, d, fp, eo, fa, da);
    chk("R12", "busy cycles with extra start", b, 1100);
    chk("R12", "single done", d, 1);
    chk("R12", "result", result, 100);
    chk("R8", "swap after restart attempt", cmp_swap, exp_swap);
  endtask

  task automatic t_sat();
    int n = 0;
    cmp_in = 1'b0;
    @(negedge clk); sat_start = 1'b1;
    @(negedge clk); sat_start = 1'b0;
    while (!sat_done && n < 5000) begin n++; @(negedge clk); end
    chk("R10", "saturated done seen", sat_done, 1);
    chk("R10", "saturated result", sat_result, 255);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_default_low();
    t_high();
    t_settle_only();
    t_prescale();
    t_zero();
    t_busy_start();
    t_sat();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule